// File: doc/BRIEF.md
# Subvector Move Index Sequencer

This block produces the stream of element index pairs that a vectorised register move walks through when the elements are grouped into subvectors. A move is described by a vector length, a subvector length for the source side, and a separate subvector length for the destination side. A single start pulse captures all of these. The block then emits one source/destination index pair per clock until the move is complete. A downstream mover reads element `src_idx` of the source group and writes it to element `dst_idx` of the destination group.

Elements use a planar layout: element `i` of lane `j` sits at offset `i + VL*j`. Each side has a walker built from two counters, an element counter `i` and a lane counter `j`, and a per-side bit chooses which counter forms the outer loop. When the lane counter is outer, the walker traverses the layout linearly. When the lane counter is inner, the walker interleaves the lanes. Setting the two sides differently turns a plain move into a zip or an unzip.

The two walkers run in lockstep. The run lasts for VL times the larger of the two subvector lengths. A walker with fewer indices keeps presenting its final index once it has used them up. A one-cycle completion flag follows the last pair.

Top module: `subvec_index_seq`

## Requirements
- R1: While reset is asserted and after it is released, with no start, `pair_valid` and `seq_done` are 0.
- R2: With its lane-outer bit set to 1, a walker with subvector length S visits `j` from 0 to S-1 in the outer loop and `i` from 0 to VL-1 in the inner loop, and presents index `i + VL*j`.
- R3: With its lane-outer bit at 0, a walker visits `i` in the outer loop and `j` in the inner loop, and presents `i + VL*j`. For example, VL=3 and S=2 give 0,3,1,4,2,5.
- R4: `src_lane_outer` sets the loop order of the source walker only, and `dst_lane_outer` sets the loop order of the destination walker only. Each side uses its own subvector length.
- R5: After a start with VL>0, `pair_valid` is 1 for exactly VL*max(src_sublen, dst_sublen) consecutive cycles. The first of these cycles is the one after the start edge, and each cycle carries the next index pair.
- R6: A walker whose own index count VL*S is smaller than the step count holds its last index (VL*S-1) for the remaining steps.
- R7: `seq_done` is 1 for exactly one cycle, the cycle right after the last valid pair, and never while `pair_valid` is 1.
- R8: A start with VL=0 produces no valid pair, and `seq_done` is 1 in the cycle after the start edge.
- R9: A start during a run abandons that run. The new run begins from index 0 on both sides in the next cycle and uses the new settings.
- R10: Changes on `vl_len`, `src_sublen`, `dst_sublen` and the two loop-order bits while a run is in progress do not affect it. Settings are captured only at a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Captures the settings and restarts the walkers |
| vl_len | input | 7 | Vector length, 0 to 64 |
| src_sublen | input | 3 | Source subvector length, 1 to 4 |
| dst_sublen | input | 3 | Destination subvector length, 1 to 4 |
| src_lane_outer | input | 1 | 1: source lane counter is the outer loop |
| dst_lane_outer | input | 1 | 1: destination lane counter is the outer loop |
| pair_valid | output | 1 | An index pair is presented this cycle |
| src_idx | output | 8 | Source element index |
| dst_idx | output | 8 | Destination element index |
| seq_done | output | 1 | One-cycle flag after the last pair |

## Verification
The bench builds the block with its default limits: a vector length of up to 64 and subvector lengths of up to 4. These defaults let a run use the largest index, 255, and the longest step count, 256, so the top bit of each index and the full width of the step counter are both exercised. Unequal subvector lengths are tried in both directions to reach the hold-last-index behaviour on each side. Every combination of the two loop-order bits is covered. Runs are also restarted in mid-flight, and settings are changed while a run is in progress.

// File: rtl/subvec_seq_pkg.sv
package subvec_seq_pkg;
  typedef enum logic {
    LANE_INNER = 1'b0,
    LANE_OUTER = 1'b1
  } loop_order_e;

  function automatic int unsigned larger(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/subvec_walker.sv
module subvec_walker
  import subvec_seq_pkg::*;
#(
  parameter int VL_W  = 7,
  parameter int SV_W  = 3,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv,
  input  logic [VL_W-1:0]  vl,
  input  logic [SV_W-1:0]  sublen,
  input  loop_order_e      order,
  output logic [IDX_W-1:0] idx
);
  logic [VL_W-1:0] elem_q, elem_d;
  logic [SV_W-1:0] lane_q, lane_d;
  logic            elem_last, lane_last, at_end;

  assign elem_last = (elem_q == VL_W'(vl - VL_W'(1)));
  assign lane_last = (lane_q == SV_W'(sublen - SV_W'(1)));
  assign at_end    = elem_last && lane_last;

  always_comb begin
    elem_d = elem_q;
    lane_d = lane_q;
    if (clear) begin
      elem_d = '0;
      lane_d = '0;
    end else if (adv && !at_end) begin
      if (order == LANE_OUTER) begin
        if (elem_last) begin
          elem_d = '0;
          lane_d = lane_q + SV_W'(1);
        end else begin
          elem_d = elem_q + VL_W'(1);
        end
      end else begin
        if (lane_last) begin
          lane_d = '0;
          elem_d = elem_q + VL_W'(1);
        end else begin
          lane_d = lane_q + SV_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_q <= '0;
      lane_q <= '0;
    end else if (clear || adv) begin
      elem_q <= elem_d;
      lane_q <= lane_d;
    end
  end

  assign idx = IDX_W'(elem_q) + IDX_W'(vl) * IDX_W'(lane_q);
endmodule

// File: rtl/subvec_step_ctl.sv
module subvec_step_ctl #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] total,
  output logic             busy,
  output logic             adv,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start) begin
      cnt_d  = '0;
      busy_d = (total != '0);
      done_d = (total == '0);
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(total - CNT_W'(1))) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign adv  = busy_q && !start;
  assign done = done_q;
endmodule

// File: rtl/subvec_index_seq.sv
module subvec_index_seq
  import subvec_seq_pkg::*;
#(
  parameter int MAX_VL    = 64,
  parameter int MAX_SUBVL = 4,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int SV_W  = $clog2(MAX_SUBVL + 1),
  localparam int IDX_W = $clog2(MAX_VL * MAX_SUBVL),
  localparam int CNT_W = $clog2(MAX_VL * MAX_SUBVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VL_W-1:0]  vl_len,
  input  logic [SV_W-1:0]  src_sublen,
  input  logic [SV_W-1:0]  dst_sublen,
  input  logic             src_lane_outer,
  input  logic             dst_lane_outer,
  output logic             pair_valid,
  output logic [IDX_W-1:0] src_idx,
  output logic [IDX_W-1:0] dst_idx,
  output logic             seq_done
);
  localparam int SIDES = 2;

  logic [VL_W-1:0]  vl_q;
  logic [SV_W-1:0]  sub_q   [SIDES];
  loop_order_e      order_q [SIDES];
  logic [SV_W-1:0]  sub_in  [SIDES];
  loop_order_e      ord_in  [SIDES];
  logic [IDX_W-1:0] idx_w   [SIDES];
  logic [SV_W-1:0]  sub_max;
  logic [CNT_W-1:0] total;
  logic             adv;

  assign sub_in[0] = src_sublen;
  assign sub_in[1] = dst_sublen;
  assign ord_in[0] = loop_order_e'(src_lane_outer);
  assign ord_in[1] = loop_order_e'(dst_lane_outer);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q <= '0;
    end else if (start) begin
      vl_q <= vl_len;
    end
  end

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sub_q[s]   <= '0;
        order_q[s] <= LANE_INNER;
      end else if (start) begin
        sub_q[s]   <= sub_in[s];
        order_q[s] <= ord_in[s];
      end
    end

    subvec_walker #(
      .VL_W (VL_W),
      .SV_W (SV_W),
      .IDX_W(IDX_W)
    ) u_walk (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start),
      .adv   (adv),
      .vl    (vl_q),
      .sublen(sub_q[s]),
      .order (order_q[s]),
      .idx   (idx_w[s])
    );
  end

  assign sub_max = SV_W'(larger(int'(sub_q[0]), int'(sub_q[1])));
  assign total   = CNT_W'(vl_len) * CNT_W'(
                     larger(int'(src_sublen), int'(dst_sublen)));

  subvec_step_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .total(total_q_sel),
    .busy (pair_valid),
    .adv  (adv),
    .done (seq_done)
  );

  logic [CNT_W-1:0] total_q_sel;
  assign total_q_sel = start ? total : CNT_W'(vl_q) * CNT_W'(sub_max);

  assign src_idx = idx_w[0];
  assign dst_idx = idx_w[1];
endmodule

module subvec_index_seq_chk #(
  parameter int VL_W  = 7,
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [VL_W-1:0]  vl_len,
  input logic             pair_valid,
  input logic [IDX_W-1:0] src_idx,
  input logic [IDX_W-1:0] dst_idx,
  input logic             seq_done
);
  a_r7_done_not_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !pair_valid);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done && !start |=> !seq_done);

  a_r5_valid_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid && !start |=> pair_valid || seq_done);

  a_r8_empty_run: assert property (@(posedge clk) disable iff (!rst_n)
    start && (vl_len == '0) |=> seq_done && !pair_valid);

  a_r9_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !pair_valid || (src_idx == '0 && dst_idx == '0));
endmodule

bind subvec_index_seq subvec_index_seq_chk #(
  .VL_W (VL_W),
  .IDX_W(IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .vl_len    (vl_len),
  .pair_valid(pair_valid),
  .src_idx   (src_idx),
  .dst_idx   (dst_idx),
  .seq_done  (seq_done)
);

// File: tb/tb_subvec_index_seq.sv
`timescale 1ns/1ps
module tb_subvec_index_seq;
  logic       clk;
  logic       rst_n;
  logic       start;
  logic [6:0] vl_len;
  logic [2:0] src_sublen, dst_sublen;
  logic       src_lane_outer, dst_lane_outer;
  logic       pair_valid, seq_done;
  logic [7:0] src_idx, dst_idx;

  int n_tests = 0;
  int n_fail  = 0;

  subvec_index_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_len(vl_len),
    .src_sublen(src_sublen), .dst_sublen(dst_sublen),
    .src_lane_outer(src_lane_outer), .dst_lane_outer(dst_lane_outer),
    .pair_valid(pair_valid), .src_idx(src_idx), .dst_idx(dst_idx),
    .seq_done(seq_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_idx(int k, int vl, int sv, bit outer);
    int n, kk, i, j;
    n  = vl * sv;
    kk = (k < n) ? k : n - 1;
    if (outer) begin i = kk % vl; j = kk / vl; end
    else       begin i = kk / sv; j = kk % sv; end
    return i + vl * j;
  endfunction

  task automatic launch(input int vl, input int s, input int d, input bit p, input bit u);
    @(negedge clk);
    vl_len = 7'(vl); src_sublen = 3'(s); dst_sublen = 3'(d);
    src_lane_outer = p; dst_lane_outer = u;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Checks a full run starting at the negedge after the start edge.
  task automatic follow(input string req, input int vl, input int s, input int d,
                        input bit p, input bit u, input bit scramble);
    int n;
    n = vl * ((s > d) ? s : d);
    if (scramble) begin
      vl_len = 7'd9; src_sublen = 3'd1; dst_sublen = 3'd4;
      src_lane_outer = ~p; dst_lane_outer = ~u;
    end
    for (int k = 0; k < n; k++) begin
      chk({req, " valid"}, int'(pair_valid), 1);
      chk({req, " src"}, int'(src_idx), exp_idx(k, vl, s, p));
      chk({req, " dst"}, int'(dst_idx), exp_idx(k, vl, d, u));
      @(negedge clk);
    end
    chk("R5 valid ends", int'(pair_valid), 0);
    chk("R7 done after last", int'(seq_done), 1);
    @(negedge clk);
    chk("R7 done one cycle", int'(seq_done), 0);
  endtask

  task automatic t_reset;
    chk("R1 valid reset", int'(pair_valid), 0);
    chk("R1 done reset", int'(seq_done), 0);
  endtask

  task automatic t_run(input string req, input int vl, input int s, input int d,
                       input bit p, input bit u);
    launch(vl, s, d, p, u);
    follow(req, vl, s, d, p, u, 1'b0);
  endtask

  task automatic t_empty;
    launch(0, 2, 3, 1'b1, 1'b0);
    chk("R8 no valid", int'(pair_valid), 0);
    chk("R8 done", int'(seq_done), 1);
    @(negedge clk);
    chk("R8 done drops", int'(seq_done), 0);
    chk("R8 still idle", int'(pair_valid), 0);
  endtask

  task automatic t_restart;
    launch(8, 4, 4, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    launch(5, 2, 3, 1'b0, 1'b1);
    follow("R9 restart", 5, 2, 3, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_ignore;
    launch(6, 3, 2, 1'b0, 1'b1);
    follow("R10 held config", 6, 3, 2, 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; vl_len = '0; src_sublen = 3'd1; dst_sublen = 3'd1;
    src_lane_outer = 1'b0; dst_lane_outer = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_run("R3 both inner", 3, 2, 2, 1'b0, 1'b0);
    t_run("R3 inner vl5", 5, 3, 3, 1'b0, 1'b0);
    t_run("R2 both outer", 4, 2, 2, 1'b1, 1'b1);
    t_run("R4 src outer only", 3, 4, 2, 1'b1, 1'b0);
    t_run("R6 src holds", 6, 1, 3, 1'b0, 1'b1);
    t_run("R6 dst holds", 1, 4, 1, 1'b0, 1'b0);
    t_run("R5 full size", 64, 4, 4, 1'b1, 1'b0);
    t_empty();
    t_restart();
    t_ignore();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule